// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block drives a two-wire serial bus as its only master. A host hands it a command word made of three bits (open a transfer, move one byte, close the transfer) together with a 7-bit target address, a direction bit, a byte to send and the acknowledge choice for a byte being received. The engine performs the requested steps in the fixed order open, move, close. Opening sends either a fresh START or, if the bus is still held from an earlier command, a repeated START, and then the address byte. Moving shifts one data byte out or in. Closing ends with a STOP. Both bus lines are open drain: the block only ever pulls a line low or lets it go, and it reads the real line levels back, so a target can stretch the clock.

The SCL period is set by a timer value `timer_prd`. One time unit is `2*(timer_prd+1)` system clocks. The low phase lasts 6 units and the high phase lasts 4 units. The commands use a valid/ready handshake. `cmd_ready` is high only while the engine is idle. While `busy` is high a host must keep its command waiting, and nothing is queued. Status flags and a received byte stay readable after each command. A completion sets a raw interrupt flag, which a mask gates onto `irq`.

Top module: `i2c_byte_master`

## Requirements
- R1: Within a byte, with no clock stretching, the SCL low phase lasts 12*(timer_prd+1) clocks, the high phase 8*(timer_prd+1) clocks, and rising edges are 20*(timer_prd+1) clocks apart. With timer_prd=9 this is 200 clocks, which gives 100 kHz from a 20 MHz clock.
- R2: An open step on an idle bus makes SDA fall while SCL is high (START). A close step makes SDA rise while SCL is high (STOP). Each command produces exactly the START and STOP conditions it asks for.
- R3: During the bit clocks SDA changes only while SCL is low. The only SDA edges with SCL high are START and STOP.
- R4: The first byte after any START is {tgt_addr[6:0], tgt_read}, sent MSB first. tgt_read=0 selects a master write and 1 a master read. The direction is latched by the open step and is used by later move steps.
- R5: Every byte takes nine SCL clocks: eight data bits sent MSB first, then an acknowledge clock in which a transmitting master releases SDA.
- R6: An address byte that is not acknowledged (SDA high on the 9th clock) sets err and addr_nack, cancels the move step, and forces a STOP. A written data byte that is not acknowledged sets err and data_nack and also forces a STOP.
- R7: On a read move step the byte is shifted in MSB first and shown on rx_byte once the step ends. In the 9th clock the master pulls SDA low if cmd_ack=1, or leaves it released (NACK) if cmd_ack=0.
- R8: An open step while the bus is still held (no STOP yet) gives a repeated START: SDA is released during SCL low, SCL is released, then SDA falls while SCL is high. A new address phase follows, and no STOP comes in between.
- R9: If a target holds SCL low, the high phase is counted only from the cycle SCL is seen high, so the high time on the line stays 8*(timer_prd+1) clocks.
- R10: Each completed command sets irq_raw. irq equals irq_raw AND irq_mask. A pulse on irq_clear clears irq_raw, but a completion in the same cycle wins.
- R11: cmd_ready is high only when idle. busy rises in the cycle after a command is accepted and stays high until every requested step, including a STOP, has finished. A move step with the bus not held sets err and makes no bus activity.
- R12: After reset both lines are released and busy, err, irq_raw and irq are low, with cmd_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_prd | input | TPW | SCL timer period value |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_start | input | 1 | Open step: START or repeated START, then address |
| cmd_run | input | 1 | Move step: one data byte |
| cmd_stop | input | 1 | Close step: STOP |
| cmd_ack | input | 1 | ACK (1) or NACK (0) for a received byte |
| tgt_addr | input | 7 | Target address |
| tgt_read | input | 1 | Direction: 1 read, 0 write |
| tx_byte | input | 8 | Byte to write |
| rx_byte | output | 8 | Last byte read |
| busy | output | 1 | Command in progress |
| err | output | 1 | Last command failed |
| addr_nack | output | 1 | Address not acknowledged |
| data_nack | output | 1 | Written byte not acknowledged |
| irq_mask | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Clear raw interrupt |
| irq_raw | output | 1 | Raw completion flag |
| irq | output | 1 | Masked interrupt |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench keeps the default TPW=8, which lets timer_prd reach 9. One directed write at that value checks the exact 120/80/200-clock phase and period figures. The rest of the traffic runs at timer_prd values from 0 to 3, so that many random read and write transfers, repeated STARTs, NACK aborts and a long clock stretch fit in a short run. A bench target model decodes the bus and checks that every high phase, and every low phase it did not stretch, has the exact length for the timer value in use.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned LOW_UNITS  = 6;
  localparam int unsigned HIGH_UNITS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_DISP, S_RS_LOW, S_ST_SETUP, S_ST_HOLD,
    S_BIT_LOW, S_BIT_HIGH, S_SP_LOW, S_SP_HIGH, S_SP_FREE, S_FINISH
  } seq_state_e;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= en ? CW'(1) : '0;
    end else if (en) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = !restart && en && (cnt == limit - CW'(1));
endmodule

// File: rtl/i2cm_irq_status.sv
module i2cm_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  input  logic mask_i,
  output logic raw_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_o <= 1'b0;
    else if (set_i)   raw_o <= 1'b1;
    else if (clear_i) raw_o <= 1'b0;
  end

  assign irq_o = raw_o & mask_i;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned TPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TPW-1:0] timer_prd,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_start,
  input  logic           cmd_run,
  input  logic           cmd_stop,
  input  logic           cmd_ack,
  input  logic [6:0]     tgt_addr,
  input  logic           tgt_read,
  input  logic [7:0]     tx_byte,
  output logic [7:0]     rx_byte,
  output logic           busy,
  output logic           err,
  output logic           addr_nack,
  output logic           data_nack,
  input  logic           irq_mask,
  input  logic           irq_clear,
  output logic           irq_raw,
  output logic           irq,
  input  logic           scl_in,
  input  logic           sda_in,
  output logic           scl_oe,
  output logic           sda_oe
);
  localparam int unsigned CW = TPW + 4;

  seq_state_e st;
  logic       entered;
  logic       owned;
  logic       pend_start, pend_run, pend_stop;
  logic [6:0] addr_q;
  logic       rw_q, ack_q, is_addr;
  logic [7:0] txd_q, shreg;
  logic [3:0] bitn;
  logic       done;

  logic [CW-1:0] unit_mult, low_len, high_len, limit;
  logic          high_phase, tm_en, expired, bit_drive;

  assign unit_mult = CW'(timer_prd) + CW'(1);
  assign low_len   = CW'(2 * LOW_UNITS) * unit_mult;
  assign high_len  = CW'(2 * HIGH_UNITS) * unit_mult;

  assign high_phase = (st == S_ST_SETUP) || (st == S_ST_HOLD) || (st == S_BIT_HIGH) ||
                      (st == S_SP_HIGH) || (st == S_SP_FREE);
  assign limit = high_phase ? high_len : low_len;
  assign tm_en = high_phase ? scl_in : 1'b1;

  i2cm_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(entered), .en(tm_en),
    .limit(limit), .expired(expired)
  );

  assign done = (st == S_FINISH);

  i2cm_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(done), .clear_i(irq_clear),
    .mask_i(irq_mask), .raw_o(irq_raw), .irq_o(irq)
  );

  // data bits: drive when sending (address or write); 9th clock: ACK on a read byte
  assign bit_drive = (bitn < 4'd8) ? ((is_addr || !rw_q) && !shreg[7])
                                   : (!is_addr && rw_q && ack_q);

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; entered <= 1'b0; owned <= 1'b0;
      pend_start <= 1'b0; pend_run <= 1'b0; pend_stop <= 1'b0;
      addr_q <= '0; rw_q <= 1'b0; ack_q <= 1'b0; is_addr <= 1'b0;
      txd_q <= '0; shreg <= '0; bitn <= '0; rx_byte <= '0;
      err <= 1'b0; addr_nack <= 1'b0; data_nack <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      entered <= 1'b0;
      case (st)
        S_IDLE: begin
          scl_oe <= owned;
          if (cmd_valid) begin
            pend_start <= cmd_start; pend_run <= cmd_run; pend_stop <= cmd_stop;
            if (cmd_start) begin
              addr_q <= tgt_addr; rw_q <= tgt_read;
            end
            txd_q <= tx_byte; ack_q <= cmd_ack;
            err <= 1'b0; addr_nack <= 1'b0; data_nack <= 1'b0;
            st <= S_DISP; entered <= 1'b1;
          end
        end
        S_DISP: begin
          entered <= 1'b1;
          if (pend_start) begin
            pend_start <= 1'b0;
            st <= owned ? S_RS_LOW : S_ST_SETUP;
          end else if (pend_run) begin
            pend_run <= 1'b0;
            if (!owned) begin
              err <= 1'b1; st <= S_FINISH;
            end else begin
              shreg <= rw_q ? 8'hFF : txd_q; is_addr <= 1'b0; bitn <= '0;
              st <= S_BIT_LOW;
            end
          end else if (pend_stop) begin
            pend_stop <= 1'b0;
            st <= owned ? S_SP_LOW : S_FINISH;
          end else begin
            st <= S_FINISH;
          end
        end
        S_RS_LOW: begin
          scl_oe <= 1'b1; sda_oe <= 1'b0;
          if (expired) begin
            scl_oe <= 1'b0; st <= S_ST_SETUP; entered <= 1'b1;
          end
        end
        S_ST_SETUP: begin
          sda_oe <= 1'b0;
          if (expired) begin
            sda_oe <= 1'b1; st <= S_ST_HOLD; entered <= 1'b1;
          end
        end
        S_ST_HOLD: begin
          if (expired) begin
            scl_oe <= 1'b1; owned <= 1'b1;
            shreg <= {addr_q, rw_q}; is_addr <= 1'b1; bitn <= '0;
            st <= S_BIT_LOW; entered <= 1'b1;
          end
        end
        S_BIT_LOW: begin
          sda_oe <= bit_drive;
          if (expired) begin
            scl_oe <= 1'b0; st <= S_BIT_HIGH; entered <= 1'b1;
          end
        end
        S_BIT_HIGH: begin
          if (expired) begin
            scl_oe <= 1'b1; entered <= 1'b1;
            if (bitn < 4'd8) begin
              shreg <= {shreg[6:0], sda_in};
              bitn  <= bitn + 4'd1;
              st    <= S_BIT_LOW;
            end else begin
              if (is_addr) begin
                if (sda_in) begin
                  err <= 1'b1; addr_nack <= 1'b1;
                  pend_run <= 1'b0; pend_stop <= 1'b1;
                end
              end else if (!rw_q) begin
                if (sda_in) begin
                  err <= 1'b1; data_nack <= 1'b1; pend_stop <= 1'b1;
                end
              end else begin
                rx_byte <= shreg;
              end
              st <= S_DISP;
            end
          end
        end
        S_SP_LOW: begin
          scl_oe <= 1'b1; sda_oe <= 1'b1;
          if (expired) begin
            scl_oe <= 1'b0; st <= S_SP_HIGH; entered <= 1'b1;
          end
        end
        S_SP_HIGH: begin
          if (expired) begin
            sda_oe <= 1'b0; st <= S_SP_FREE; entered <= 1'b1;
          end
        end
        S_SP_FREE: begin
          if (expired) begin
            owned <= 1'b0; st <= S_FINISH; entered <= 1'b1;
          end
        end
        S_FINISH: begin
          st <= S_IDLE; entered <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       err,
  input logic       addr_nack,
  input logic       irq_clear,
  input logic       irq_raw,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       owned,
  input logic       done,
  input seq_state_e st
);
  // R3: SDA drive held while a bit's high phase runs
  assert_sda_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT_HIGH && $past(st) == S_BIT_HIGH) |-> $stable(sda_oe));

  // R11: an accepted command makes the engine busy next cycle
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R12: idle and not holding the bus means both lines released
  assert_lines_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !owned) |-> (!scl_oe && !sda_oe));

  // R10: completion sets the raw flag, a lone clear removes it
  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_raw);
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !done) |=> !irq_raw);

  // R6: an address NACK always reports an error
  assert_addr_nack_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_nack) |-> err);
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .err(err), .addr_nack(addr_nack), .irq_clear(irq_clear),
  .irq_raw(irq_raw), .scl_oe(scl_oe), .sda_oe(sda_oe), .owned(owned),
  .done(done), .st(st)
);

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  localparam int TPW = 8;
  localparam logic [6:0] SLV = 7'h3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [TPW-1:0] tp_b = '0;
  logic cmd_valid = 0, cmd_start = 0, cmd_run = 0, cmd_stop = 0, cmd_ack = 0;
  logic [6:0] tgt_addr = '0;
  logic tgt_read = 0;
  logic [7:0] tx_byte = '0;
  logic irq_mask = 0, irq_clear = 0;
  logic cmd_ready, busy, err, addr_nack, data_nack, irq_raw, irq, scl_oe, sda_oe;
  logic [7:0] rx_byte;

  logic s_sda = 0;
  int   hold_cnt = 0;
  wire  scl_line = !(scl_oe || (hold_cnt != 0));
  wire  sda_line = !(sda_oe || s_sda);

  i2c_byte_master #(.TPW(TPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .timer_prd(tp_b), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_start(cmd_start), .cmd_run(cmd_run),
    .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .tgt_addr(tgt_addr),
    .tgt_read(tgt_read), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy),
    .err(err), .addr_nack(addr_nack), .data_nack(data_nack),
    .irq_mask(irq_mask), .irq_clear(irq_clear), .irq_raw(irq_raw), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_rd(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  // ---------------- target model ----------------
  logic scl_p = 1, sda_p = 1, first = 0, in_addr = 0, active = 0, s_rw = 0;
  logic sending = 0, mack = 0, stretched = 0, nack_data = 0;
  logic [7:0] sh = '0, shtx = '0;
  int bc = 0, rdi = 0, n_start = 0, n_stop = 0, slog_n = 0, stretch_len = 0;
  int t_rise = 0, t_fall = 0, tim_bad = 0, last_low = 0, last_high = 0;
  int last_per = 0, str_low = 0;
  logic [7:0] slog [0:255];

  always @(posedge clk) begin
    if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
    scl_p <= scl_line; sda_p <= sda_line;
    if (rst_n) begin
      if (scl_line && scl_p && sda_p && !sda_line) begin
        n_start <= n_start + 1; bc <= 0; first <= 1; in_addr <= 1;
        s_sda <= 0; sending <= 0; active <= 0;
      end else if (scl_line && scl_p && !sda_p && sda_line) begin
        n_stop <= n_stop + 1; in_addr <= 0; active <= 0; sending <= 0; s_sda <= 0;
      end else if (scl_line && !scl_p) begin
        if (bc >= 1) begin
          if (!stretched && (cyc - t_fall) != 12 * (int'(tp_b) + 1)) tim_bad <= tim_bad + 1;
          if (stretched) str_low <= cyc - t_fall;
          else last_low <= cyc - t_fall;
          last_per <= cyc - t_rise;
        end
        stretched <= 0; t_rise <= cyc;
        if (bc < 8) sh <= {sh[6:0], sda_line};
        else mack <= sda_line;
      end else if (!scl_line && scl_p) begin
        t_fall <= cyc;
        if (first) begin
          first <= 0;
        end else begin
          if ((cyc - t_rise) != 8 * (int'(tp_b) + 1)) tim_bad <= tim_bad + 1;
          last_high <= cyc - t_rise;
          if (bc < 7) begin
            bc <= bc + 1;
            if (sending) s_sda <= !shtx[6 - bc];
            if (bc == 2 && !in_addr && stretch_len > 0) begin
              hold_cnt <= stretch_len; stretched <= 1;
            end
          end else if (bc == 7) begin
            bc <= 8;
            if (in_addr) begin
              active <= (sh[7:1] == SLV); s_rw <= sh[0];
              slog[slog_n] <= sh; slog_n <= slog_n + 1;
              s_sda <= (sh[7:1] == SLV);
            end else if (sending) begin
              s_sda <= 0; sending <= 0;
            end else if (active && !s_rw) begin
              slog[slog_n] <= sh; slog_n <= slog_n + 1;
              s_sda <= !nack_data;
            end else begin
              s_sda <= 0;
            end
          end else begin
            bc <= 0; in_addr <= 0;
            if (active && s_rw && (in_addr || !mack)) begin
              shtx <= exp_rd(rdi); s_sda <= !exp_rd(rdi)[7];
              rdi <= rdi + 1; sending <= 1;
            end else begin
              s_sda <= 0;
            end
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  logic [7:0] elog [0:255];
  int elog_n = 0, lchk = 0, e_start = 0, e_stop = 0, e_rdi = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_bus(input string tag);
    chk({tag, " byte count"}, slog_n, elog_n);
    for (int i = lchk; i < elog_n; i++)
      if (i < slog_n) chk({tag, " byte"}, int'(slog[i]), int'(elog[i]));
    lchk = elog_n;
    chk("R2 START count", n_start, e_start);
    chk("R2 STOP count", n_stop, e_stop);
  endtask

  task automatic push(input logic [7:0] b);
    elog[elog_n] = b; elog_n++;
  endtask

  task automatic do_cmd(input logic s, input logic r, input logic p, input logic a,
                        input logic [6:0] ad, input logic rd, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_start = s; cmd_run = r; cmd_stop = p; cmd_ack = a;
    tgt_addr = ad; tgt_read = rd; tx_byte = d;
    @(negedge clk);
    cmd_valid = 0;
    chk("R11 busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc >= 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    chk("R12 reset scl_oe", int'(scl_oe), 0);
    chk("R12 reset busy", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 lines released", int'({scl_oe, sda_oe}), 0);
    chk("R12 irq idle", int'({irq_raw, irq, err}), 0);
    chk("R12 ready", int'(cmd_ready), 1);

    // R11: move step with no bus held
    do_cmd(0, 1, 0, 0, SLV, 0, 8'h11);
    chk("R11 run without bus err", int'(err), 1);
    check_bus("R11 no activity");

    // R1 R4 R5: write at timer 9
    tp_b = 9;
    do_cmd(1, 1, 1, 0, SLV, 0, 8'hA5);
    e_start++; e_stop++; push({SLV, 1'b0}); push(8'hA5);
    check_bus("R4 R5 write");
    chk("R5 write acked", int'({err, data_nack}), 0);
    chk("R1 low 120", last_low, 120);
    chk("R1 high 80", last_high, 80);
    chk("R1 period 200", last_per, 200);

    // R10 interrupt
    chk("R10 raw set", int'(irq_raw), 1);
    chk("R10 masked", int'(irq), 0);
    irq_mask = 1; @(negedge clk);
    chk("R10 irq on", int'(irq), 1);
    irq_clear = 1; @(negedge clk); irq_clear = 0;
    chk("R10 cleared", int'({irq_raw, irq}), 0);
    irq_mask = 0;

    // R6 address NACK
    tp_b = 1;
    do_cmd(1, 1, 0, 0, 7'h12, 0, 8'h77);
    e_start++; e_stop++; push({7'h12, 1'b0});
    check_bus("R6 addr nack");
    chk("R6 addr nack flags", int'({err, addr_nack, data_nack}), 3'b110);

    // R6 data NACK
    nack_data = 1;
    do_cmd(1, 1, 0, 0, SLV, 0, 8'h3C);
    e_start++; e_stop++; push({SLV, 1'b0}); push(8'h3C);
    check_bus("R6 data nack");
    chk("R6 data nack flags", int'({err, addr_nack, data_nack}), 3'b101);
    nack_data = 0;

    // R7 read two bytes, ACK then NACK
    do_cmd(1, 1, 0, 1, SLV, 1, 8'h00);
    e_start++; push({SLV, 1'b1});
    chk("R7 rx byte0", int'(rx_byte), int'(exp_rd(e_rdi))); e_rdi++;
    chk("R7 master ACK", int'(mack), 0);
    do_cmd(0, 1, 1, 0, SLV, 0, 8'h00);
    e_stop++;
    chk("R7 rx byte1", int'(rx_byte), int'(exp_rd(e_rdi))); e_rdi++;
    chk("R7 master NACK", int'(mack), 1);
    check_bus("R4 R7 read");

    // R8 repeated START
    do_cmd(1, 1, 0, 0, SLV, 0, 8'h5A);
    e_start++; push({SLV, 1'b0}); push(8'h5A);
    do_cmd(1, 1, 0, 0, SLV, 1, 8'h00);
    e_start++; push({SLV, 1'b1});
    chk("R8 no STOP between", n_stop, e_stop);
    chk("R8 rx after restart", int'(rx_byte), int'(exp_rd(e_rdi))); e_rdi++;
    do_cmd(0, 0, 1, 0, SLV, 0, 8'h00);
    e_stop++;
    check_bus("R8 restart");

    // R9 clock stretching
    stretch_len = 100;
    do_cmd(1, 1, 1, 0, SLV, 0, 8'hC3);
    e_start++; e_stop++; push({SLV, 1'b0}); push(8'hC3);
    stretch_len = 0;
    check_bus("R9 stretch data");
    chk("R9 stretched low seen", int'(str_low > 100), 1);
    chk("R9 timing intact", tim_bad, 0);

    // random mix
    for (int k = 0; k < 16; k++) begin
      int nb;
      logic rd, bad;
      logic [6:0] ad;
      tp_b = TPW'($urandom_range(0, 3));
      nb = $urandom_range(1, 3);
      rd = 1'($urandom_range(0, 1));
      bad = ($urandom_range(0, 7) == 0);
      ad = bad ? (SLV ^ 7'h40) : SLV;
      if (bad) begin
        do_cmd(1, 1, 1, 0, ad, rd, 8'hEE);
        e_start++; e_stop++; push({ad, rd});
        chk("R6 random addr nack", int'(addr_nack), 1);
      end else if (!rd) begin
        for (int b = 0; b < nb; b++) begin
          logic [7:0] d;
          d = 8'($urandom);
          do_cmd(b == 0, 1, b == nb - 1, 0, ad, 0, d);
          if (b == 0) begin e_start++; push({ad, 1'b0}); end
          push(d);
          chk("R5 random write ok", int'(err), 0);
        end
        e_stop++;
      end else begin
        for (int b = 0; b < nb; b++) begin
          do_cmd(b == 0, 1, b == nb - 1, b != nb - 1, ad, 1, 8'h00);
          if (b == 0) begin e_start++; push({ad, 1'b1}); end
          chk("R7 random read", int'(rx_byte), int'(exp_rd(e_rdi))); e_rdi++;
        end
        e_stop++;
      end
      check_bus("R4 random");
    end
    chk("R1 R3 R9 timing all", tim_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule